// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight hardware lock flags that two independent ports, left and right, share. Each port reaches the flags through its own synchronous interface, with an active-low select, a write strobe, an active-low output enable, a 3-bit flag address and a 16-bit data bus. Both ports run on one common clock. A port asks for a flag by writing 0 to it and gives the flag back by writing 1. The port then reads the flag to learn whether it holds the token. The owner reads 0 and the other port reads 1.

Each flag keeps one request latch per port. An arbitration stage hands ownership to at most one port at a time. A request that arrives while the other port owns the flag stays queued in its latch. When the owner releases the flag, the token passes to the queued port on that same clock edge. Read data is captured when a read window opens and is held for the whole window, so a write from the other port cannot change it while the read is in progress.

Software is still expected to write 1 to every flag from both ports during initialization. The synchronous reset only places all flags in the free state.

Top module: `sem_bank`

## Requirements
- R1: A semaphore write happens only on a clock edge where the port's select is low (0) and its write strobe is high (1). A write strobe while select is high changes no flag.
- R2: A write uses only data bit 0. Bits 15:1 have no effect. A 0 in bit 0 sets that port's request latch for the addressed flag, and a 1 clears it.
- R3: After a port requests a free flag, that port's view of the flag is 0 and the other port's view is 1, from the clock edge that takes the write. The two views are never 0 at the same time.
- R4: An owned flag stays with its owner until the owner writes 1. A 0 written by the other port is queued and does not disturb the owner.
- R5: When the owner writes 1 while the other port has a queued request, ownership passes to the other port on the same edge. If no request is queued, both views return to 1.
- R6: A repeated write of 0 by the owner, or a write of 1 by a port whose request latch is clear, leaves the flag state unchanged.
- R7: Read data is the addressed flag's view for that port, copied onto all 16 bits (all ones or all zeros). Read data is zero whenever the port's read window is closed.
- R8: The read window is select low and output enable low. Read data is captured on the first clock edge of the window, one register after the inputs, and held unchanged while the window stays open, even if the flag changes.
- R9: If both ports request the same free flag on the same edge, the left port wins and the right request stays queued. The right port then gets the flag when the left port releases it.
- R10: A synchronous active-high reset clears all request latches, frees every flag (both views 1) and clears both read registers.
- R11: The flag address selects one of eight independent flags. An access to one flag never changes another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| lft_sel_n | input | 1 | Left semaphore select, active low |
| lft_wr | input | 1 | Left write strobe, active high |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | 3 | Left flag address |
| lft_wdata | input | 16 | Left write data (bit 0 used) |
| lft_rdata | output | 16 | Left read data |
| rgt_sel_n | input | 1 | Right semaphore select, active low |
| rgt_wr | input | 1 | Right write strobe, active high |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | 3 | Right flag address |
| rgt_wdata | input | 16 | Right write data (bit 0 used) |
| rgt_rdata | output | 16 | Right read data |

## Verification
The read-hold property assumes that each port keeps its select and output enable inactive while reset is high. Without that, a window that was already open during reset would capture a new value on the first edge after reset. The properties also assume that a port does not raise its write strobe and its output enable in the same cycle. The random stimulus draws, for each port and each cycle, one of three operations (idle, write or read), so write and read never overlap on a port. It holds every input idle during reset. The random stimulus also keeps reads open for several cycles, so that held windows see writes from the other port.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_LFT  = 2'd1,
        OWN_RGT  = 2'd2
    } owner_e;

    typedef struct packed {
        logic set;
        logic clr;
    } req_cmd_t;

    // Owner after this edge, given the request latches after this edge.
    function automatic owner_e next_owner(owner_e cur, logic req_l, logic req_r);
        owner_e nxt;
        case (cur)
            OWN_LFT:  nxt = req_l ? OWN_LFT : (req_r ? OWN_RGT : OWN_NONE);
            OWN_RGT:  nxt = req_r ? OWN_RGT : (req_l ? OWN_LFT : OWN_NONE);
            default:  nxt = req_l ? OWN_LFT : (req_r ? OWN_RGT : OWN_NONE);
        endcase
        return nxt;
    endfunction

    function automatic logic latch_next(logic cur, req_cmd_t cmd);
        logic nxt;
        if (cmd.set)      nxt = 1'b1;
        else if (cmd.clr) nxt = 1'b0;
        else              nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/sem_port.sv
module sem_port
    import sem_pkg::*;
#(
    parameter int N_FLAGS = 8,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_n,
    input  logic                wr,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [N_FLAGS-1:0]  view,
    output req_cmd_t            cmd [N_FLAGS],
    output logic [DATA_W-1:0]   rdata
);

    logic wr_hit;
    logic rd_on;
    logic rd_on_q;
    logic [DATA_W-1:0] rd_q;
    logic unused_hi;

    assign wr_hit    = !sel_n && wr;
    assign rd_on     = !sel_n && !oe_n;
    assign unused_hi = ^wdata[DATA_W-1:1];

    always_comb begin
        for (int i = 0; i < N_FLAGS; i++) begin
            cmd[i].set = wr_hit && (addr == ADDR_W'(i)) && !wdata[0];
            cmd[i].clr = wr_hit && (addr == ADDR_W'(i)) &&  wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_on_q <= 1'b0;
            rd_q    <= '0;
        end else begin
            rd_on_q <= rd_on;
            if (rd_on && !rd_on_q)
                rd_q <= {DATA_W{view[addr]}};
            else if (!rd_on)
                rd_q <= '0;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/sem_flag.sv
module sem_flag
    import sem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_cmd_t cmd_l,
    input  req_cmd_t cmd_r,
    output logic     view_l,
    output logic     view_r
);

    logic   req_l_q, req_r_q;
    logic   req_l_d, req_r_d;
    owner_e own_q;

    assign req_l_d = latch_next(req_l_q, cmd_l);
    assign req_r_d = latch_next(req_r_q, cmd_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_l_q <= 1'b0;
            req_r_q <= 1'b0;
            own_q   <= OWN_NONE;
        end else begin
            req_l_q <= req_l_d;
            req_r_q <= req_r_d;
            own_q   <= next_owner(own_q, req_l_d, req_r_d);
        end
    end

    assign view_l = (own_q != OWN_LFT);
    assign view_r = (own_q != OWN_RGT);

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int  N_FLAGS = 8,
    parameter int  DATA_W  = 16,
    localparam int ADDR_W  = $clog2(N_FLAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lft_sel_n,
    input  logic              lft_wr,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              rgt_sel_n,
    input  logic              rgt_wr,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata
);

    req_cmd_t           cmd_l [N_FLAGS];
    req_cmd_t           cmd_r [N_FLAGS];
    logic [N_FLAGS-1:0] lft_view;
    logic [N_FLAGS-1:0] rgt_view;

    sem_port #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lft (
        .clk(clk), .rst(rst), .sel_n(lft_sel_n), .wr(lft_wr), .oe_n(lft_oe_n),
        .addr(lft_addr), .wdata(lft_wdata), .view(lft_view), .cmd(cmd_l),
        .rdata(lft_rdata)
    );

    sem_port #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rgt (
        .clk(clk), .rst(rst), .sel_n(rgt_sel_n), .wr(rgt_wr), .oe_n(rgt_oe_n),
        .addr(rgt_addr), .wdata(rgt_wdata), .view(rgt_view), .cmd(cmd_r),
        .rdata(rgt_rdata)
    );

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        sem_flag u_flag (
            .clk(clk), .rst(rst), .cmd_l(cmd_l[g]), .cmd_r(cmd_r[g]),
            .view_l(lft_view[g]), .view_r(rgt_view[g])
        );
    end

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int N_FLAGS = 8,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              lft_sel_n,
    input logic              lft_wr,
    input logic              lft_oe_n,
    input logic [ADDR_W-1:0] lft_addr,
    input logic [DATA_W-1:0] lft_wdata,
    input logic [DATA_W-1:0] lft_rdata,
    input logic              rgt_sel_n,
    input logic              rgt_wr,
    input logic              rgt_oe_n,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic [DATA_W-1:0] rgt_wdata,
    input logic [DATA_W-1:0] rgt_rdata,
    input logic [N_FLAGS-1:0] lft_view,
    input logic [N_FLAGS-1:0] rgt_view
);

    logic l_rd, r_rd;
    assign l_rd = !lft_sel_n && !lft_oe_n;
    assign r_rd = !rgt_sel_n && !rgt_oe_n;

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        ((~lft_view & ~rgt_view) == '0));                                   // R3

    AST_RESET_FREE: assert property (@(posedge clk)
        rst |=> (&lft_view && &rgt_view && lft_rdata == '0 && rgt_rdata == '0)); // R10

    AST_LFT_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (lft_rdata == '0) || (lft_rdata == '1));                            // R7

    AST_RGT_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (rgt_rdata == '0) || (rgt_rdata == '1));                            // R7

    AST_LFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (l_rd && $past(l_rd)) |=> $stable(lft_rdata));                      // R8

    AST_RGT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (r_rd && $past(r_rd)) |=> $stable(rgt_rdata));                      // R8

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_own
        logic l_rel, r_rel;
        assign l_rel = !lft_sel_n && lft_wr && lft_wdata[0] && (lft_addr == ADDR_W'(g));
        assign r_rel = !rgt_sel_n && rgt_wr && rgt_wdata[0] && (rgt_addr == ADDR_W'(g));

        AST_LFT_KEEP: assert property (@(posedge clk) disable iff (rst)
            (!lft_view[g] && !l_rel) |=> !lft_view[g]);                     // R4

        AST_RGT_KEEP: assert property (@(posedge clk) disable iff (rst)
            (!rgt_view[g] && !r_rel) |=> !rgt_view[g]);                     // R4
    end

endmodule

bind sem_bank sem_bank_chk #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .lft_sel_n(lft_sel_n), .lft_wr(lft_wr), .lft_oe_n(lft_oe_n),
    .lft_addr(lft_addr), .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
    .rgt_sel_n(rgt_sel_n), .rgt_wr(rgt_wr), .rgt_oe_n(rgt_oe_n),
    .rgt_addr(rgt_addr), .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata),
    .lft_view(lft_view), .rgt_view(rgt_view)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lsel = 1'b1, lwr = 1'b0, loe = 1'b1;
    logic [2:0]  laddr = '0;
    logic [15:0] lwd = '0;
    logic        rsel = 1'b1, rwr = 1'b0, roe = 1'b1;
    logic [2:0]  raddr = '0;
    logic [15:0] rwd = '0;
    logic [15:0] lft_rdata, rgt_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference: 0 free, 1 left, 2 right
    logic [7:0]  m_rl, m_rr;
    int          m_own [8];
    logic [15:0] m_rd_l, m_rd_r;
    logic        m_act_l, m_act_r;

    always #5 clk = ~clk;

    sem_bank dut (
        .clk(clk), .rst(rst),
        .lft_sel_n(lsel), .lft_wr(lwr), .lft_oe_n(loe), .lft_addr(laddr),
        .lft_wdata(lwd), .lft_rdata(lft_rdata),
        .rgt_sel_n(rsel), .rgt_wr(rwr), .rgt_oe_n(roe), .rgt_addr(raddr),
        .rgt_wdata(rwd), .rgt_rdata(rgt_rdata)
    );

    function automatic int arb(int cur, logic rl, logic rr);
        if (cur == 1 && rl) return 1;
        if (cur == 2 && rr) return 2;
        if (cur == 2) return rl ? 1 : 0;
        if (cur == 1) return rr ? 2 : 0;
        return rl ? 1 : (rr ? 2 : 0);
    endfunction

    task automatic model_edge();
        logic al, ar;
        if (rst) begin
            m_rl = '0; m_rr = '0; m_rd_l = '0; m_rd_r = '0;
            m_act_l = 0; m_act_r = 0;
            for (int i = 0; i < 8; i++) m_own[i] = 0;
            return;
        end
        al = !lsel && !loe;
        ar = !rsel && !roe;
        if (al && !m_act_l) m_rd_l = {16{m_own[laddr] != 1}};
        else if (!al)       m_rd_l = '0;
        if (ar && !m_act_r) m_rd_r = {16{m_own[raddr] != 2}};
        else if (!ar)       m_rd_r = '0;
        m_act_l = al; m_act_r = ar;
        if (!lsel && lwr) m_rl[laddr] = !lwd[0];
        if (!rsel && rwr) m_rr[raddr] = !rwd[0];
        for (int i = 0; i < 8; i++) m_own[i] = arb(m_own[i], m_rl[i], m_rr[i]);
    endtask

    task automatic check(string tag, string side, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s rdata: actual %h expected %h", tag, side, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "left", lft_rdata, m_rd_l);
        check(tag, "right", rgt_rdata, m_rd_r);
    endtask

    task automatic idle();
        lsel = 1; lwr = 0; loe = 1; rsel = 1; rwr = 0; roe = 1;
    endtask

    task automatic lwrite(int a, logic [15:0] d);
        lsel = 0; lwr = 1; loe = 1; laddr = 3'(a); lwd = d;
    endtask

    task automatic rwrite(int a, logic [15:0] d);
        rsel = 0; rwr = 1; roe = 1; raddr = 3'(a); rwd = d;
    endtask

    task automatic lread(int a);
        lsel = 0; lwr = 0; loe = 0; laddr = 3'(a);
    endtask

    task automatic rread(int a);
        rsel = 0; rwr = 0; roe = 0; raddr = 3'(a);
    endtask

    // read flag a on both ports and compare; closes the window afterwards
    task automatic peek(int a, string tag);
        idle(); lread(a); rread(a); step(tag);
        idle(); step(tag);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        step("R10");
        step("R10");
        rst = 0;
        step("R10");
        for (int i = 0; i < 8; i++) peek(i, "R10");

        // R1: write strobe with select high does nothing
        idle(); lwr = 1; laddr = 3'd1; lwd = 16'h0000; step("R1");
        peek(1, "R1");

        // R2 + R3: upper bits set, bit0 = 0 is a request
        idle(); lwrite(1, 16'hFFFE); step("R2");
        peek(1, "R3");

        // R4: right request queued, left keeps it
        idle(); rwrite(1, 16'h0000); step("R4");
        peek(1, "R4");

        // R8: right holds read window while left releases (handoff R5)
        idle(); rread(1); step("R8");
        lwrite(1, 16'h0001); step("R8");
        idle(); rread(1); step("R8");
        step("R8");
        idle(); step("R8");
        peek(1, "R5");

        // R6: owner repeats request, left releases with no request
        idle(); rwrite(1, 16'h0000); lwrite(1, 16'h0001); step("R6");
        peek(1, "R6");

        // R5: release without queued request frees the flag
        idle(); rwrite(1, 16'hFFFF); step("R5");
        peek(1, "R5");

        // R9: same-edge tie goes to left, right gets it after release
        idle(); lwrite(5, 16'h0000); rwrite(5, 16'h0000); step("R9");
        peek(5, "R9");
        idle(); lwrite(5, 16'h0001); step("R9");
        peek(5, "R9");
        idle(); rwrite(5, 16'h0001); step("R9");
        peek(5, "R9");

        // R11: each flag independent
        idle(); lwrite(3, 16'h0); rwrite(4, 16'h0); step("R11");
        for (int i = 0; i < 8; i++) peek(i, "R11");

        // random mix
        void'($urandom(32'h5EA1));
        for (int n = 0; n < 6000; n++) begin
            int lo, ro;
            lo = $urandom_range(0, 5);
            ro = $urandom_range(0, 5);
            if (lo == 0) begin lsel = 1; lwr = 0; loe = 1; end
            else if (lo == 1) lwrite($urandom_range(0, 7), 16'($urandom()));
            else if (lo == 2 || !m_act_l) lread($urandom_range(0, 7));
            if (ro == 0) begin rsel = 1; rwr = 0; roe = 1; end
            else if (ro == 1) rwrite($urandom_range(0, 7), 16'($urandom()));
            else if (ro == 2 || !m_act_r) rread($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) lwr = 1;
            if (lwr && lsel == 0) loe = 1;
            step("R7/R11");
        end

        idle(); rst = 1; step("R10");
        rst = 0; step("R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule